// File: doc/BRIEF.md
# Serial Prefix Codeword Decoder

This block sits between an external tester and on-chip decompression logic. The tester sends a compressed stream one bit per clock. The block walks a fixed prefix-free variable-length code, and on the last bit of each codeword it reports the codeword's position in the code table as a binary index. It then holds the tester off until the consuming controller says it can take the next codeword.

The code table is set at elaboration time through two packed parameters.

- `CW_BITS` holds each codeword right-aligned in its own `MAX_LEN`-bit slice, with the first-received bit as the most significant bit used.
- `CW_LENS` holds each codeword's length.

The default table has five codewords: `0`, `10`, `110`, `1110` and `1111`, at indices 0 to 4. Shorter codewords are meant for the symbols that occur most often. The index means nothing to this block. The controller reads it as a scan source, a run length or a data block, depending on its own mode.

### States

| State | Meaning |
|---|---|
| `ST_ROOT` | No bits of the current codeword have been taken yet. |
| `ST_WALK` | Part of a codeword has been taken. |
| `ST_HOLD` | A codeword has been reported; the tester is held off. |

### Transitions

| Transition | Condition |
|---|---|
| `ST_ROOT`→`ST_WALK` | A bit is taken and it does not complete a codeword. |
| `ST_ROOT`→`ST_HOLD` | A one-bit codeword completes. |
| `ST_WALK`→`ST_WALK` | A bit is taken and it still completes no codeword. |
| `ST_WALK`→`ST_HOLD` | A codeword completes. |
| `ST_WALK`→`ST_ROOT` | `MAX_LEN` bits have been taken with no match (only possible with an incomplete table). |
| `ST_HOLD`→`ST_ROOT` | The consumer's ready input is seen. |

Top module: `pfx_cw_decoder`

## Requirements
- R1: While `rst` is sampled high, and at the first sample after it, `tx_go` is 1 and `sym_vld` is 0.
- R2: A bit on `tx_data` is taken only at a rising edge where both `tx_strobe` and `tx_go` are 1. Idle cycles in the middle of a codeword neither advance nor reset the decode.
- R3: A codeword is recognised on its last bit. The index is its table position, with the first bit written leftmost: `0`→0, `10`→1, `110`→2, `1110`→3, `1111`→4. The index is always below N.
- R4: `sym_idx` and `sym_vld` are registered and appear at the edge that samples the codeword's last bit. `sym_vld` is high for exactly one cycle.
- R5: `tx_go` goes to 0 at the same edge as `sym_vld` rises. It stays 0 while `rx_ready` is sampled 0.
- R6: When `rx_ready` is sampled 1 while `tx_go` is 0, `tx_go` is 1 after that edge. The next bit then starts a new codeword.
- R7: Bits strobed while `tx_go` is 0 are ignored. They produce no `sym_vld` and do not become part of the next codeword.
- R8: `sym_idx` keeps its value until the next codeword completes.
- R9: A reset in the middle of a codeword discards the bits already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (tester bit rate) |
| rst | input | 1 | Synchronous reset, active high |
| tx_data | input | 1 | Serial compressed bit |
| tx_strobe | input | 1 | Tester is presenting a bit this cycle |
| tx_go | output | 1 | Handshake to tester: 1 = send, 0 = pause |
| rx_ready | input | 1 | Consumer can accept the next codeword |
| sym_idx | output | IDX_W | Index of the last decoded codeword |
| sym_vld | output | 1 | One-cycle pulse: `sym_idx` is new |

## Verification
Every result here is due at a fixed number of edges after its stimulus.

- **Last bit of a codeword.** The bench drives each bit at a falling edge and returns at the next falling edge. At that point the index, the valid pulse and the low handshake are all visible, so they are checked there.
- **Valid pulse width.** One cycle later, valid must be low again.
- **Ready.** A ready driven at a falling edge must show `tx_go` high at the next falling edge.
- **While held off.** Each falling edge in the hold checks that the handshake stays low, that valid stays low and that the index holds.

The sweep covers every ordered pair of the five codewords, with zero to two cycles of ready delay, optional gaps between bits, and optional junk bits strobed during the hold. The expected index is computed from the symbol number in the bench.

// File: rtl/pfx_cw_pkg.sv
package pfx_cw_pkg;

    typedef enum logic [1:0] {
        ST_ROOT = 2'd0,
        ST_WALK = 2'd1,
        ST_HOLD = 2'd2
    } dec_state_t;

    // Default table: five codewords, each right-aligned in a 4-bit slice,
    // slice i holds codeword i (first received bit is the highest used bit).
    localparam logic [19:0] PFX_DFLT_BITS = {4'b1111, 4'b1110, 4'b0110, 4'b0010, 4'b0000};
    localparam logic [14:0] PFX_DFLT_LENS = {3'd4, 3'd4, 3'd3, 3'd2, 3'd1};

endpackage

// File: rtl/pfx_cw_shifter.sv
// Collects the bits of the codeword in progress and offers the candidate
// path (taken bits plus the bit on the input) to the matcher.
module pfx_cw_shifter #(
    parameter int MAX_LEN = 4,
    parameter int LEN_W   = 3,
    localparam int ACC_W  = MAX_LEN - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               clear,
    input  logic               bit_in,
    output logic [MAX_LEN-1:0] cand_bits,
    output logic [LEN_W-1:0]   cand_len
);

    logic [ACC_W-1:0] acc_q;
    logic [LEN_W-1:0] cnt_q;

    assign cand_bits = {acc_q, bit_in};
    assign cand_len  = cnt_q + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            acc_q <= cand_bits[ACC_W-1:0];
            cnt_q <= cand_len;
        end
    end

endmodule

// File: rtl/pfx_cw_match.sv
// Compares the candidate path against every table entry in parallel.
module pfx_cw_match #(
    parameter int N_CW    = 5,
    parameter int MAX_LEN = 4,
    parameter int LEN_W   = 3,
    parameter int IDX_W   = 3,
    parameter logic [N_CW*MAX_LEN-1:0] CW_BITS = '0,
    parameter logic [N_CW*LEN_W-1:0]   CW_LENS = '0
) (
    input  logic [MAX_LEN-1:0] cand_bits,
    input  logic [LEN_W-1:0]   cand_len,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx
);

    logic [N_CW-1:0] match_vec;

    for (genvar gi = 0; gi < N_CW; gi++) begin : g_entry
        localparam logic [MAX_LEN-1:0] CB = CW_BITS[gi*MAX_LEN +: MAX_LEN];
        localparam logic [LEN_W-1:0]   CL = CW_LENS[gi*LEN_W +: LEN_W];
        logic mism;
        always_comb begin
            mism = 1'b0;
            for (int b = 0; b < MAX_LEN; b++) begin
                if (b < int'(CL)) mism = mism | (cand_bits[b] ^ CB[b]);
            end
        end
        assign match_vec[gi] = (cand_len == CL) && !mism;
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N_CW - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match_vec;

endmodule

// File: rtl/pfx_cw_fsm.sv
// Handshake state machine and registered outputs.
module pfx_cw_fsm
    import pfx_cw_pkg::*;
#(
    parameter int MAX_LEN = 4,
    parameter int LEN_W   = 3,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_strobe,
    input  logic             rx_ready,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic [LEN_W-1:0] cand_len,
    output logic             shift_en,
    output logic             clear,
    output logic             tx_go,
    output logic [IDX_W-1:0] sym_idx,
    output logic             sym_vld
);

    dec_state_t st_q, st_nx;
    logic take, full;

    assign take     = tx_strobe && (st_q != ST_HOLD);
    assign full     = (cand_len == LEN_W'(MAX_LEN));
    assign shift_en = take;
    assign clear    = take && (hit || full);

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_ROOT: begin
                if (take && hit)  st_nx = ST_HOLD;
                else if (take)    st_nx = ST_WALK;
            end
            ST_WALK: begin
                if (take && hit)  st_nx = ST_HOLD;
                else if (take && full) st_nx = ST_ROOT;
            end
            ST_HOLD: begin
                if (rx_ready)     st_nx = ST_ROOT;
            end
            default:              st_nx = ST_ROOT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_ROOT;
        else     st_q <= st_nx;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_go   <= 1'b1;
            sym_vld <= 1'b0;
            sym_idx <= '0;
        end else begin
            tx_go   <= (st_nx != ST_HOLD);
            sym_vld <= take && hit;
            if (take && hit) sym_idx <= hit_idx;
        end
    end

endmodule

// File: rtl/pfx_cw_decoder.sv
module pfx_cw_decoder
    import pfx_cw_pkg::*;
#(
    parameter int N_CW    = 5,
    parameter int MAX_LEN = 4,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter logic [N_CW*MAX_LEN-1:0] CW_BITS = PFX_DFLT_BITS,
    parameter logic [N_CW*LEN_W-1:0]   CW_LENS = PFX_DFLT_LENS,
    localparam int IDX_W  = (N_CW > 1) ? $clog2(N_CW) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_data,
    input  logic             tx_strobe,
    output logic             tx_go,
    input  logic             rx_ready,
    output logic [IDX_W-1:0] sym_idx,
    output logic             sym_vld
);

    logic [MAX_LEN-1:0] cand_bits;
    logic [LEN_W-1:0]   cand_len;
    logic               hit, shift_en, clear;
    logic [IDX_W-1:0]   hit_idx;

    pfx_cw_shifter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst(rst), .shift_en(shift_en), .clear(clear),
        .bit_in(tx_data), .cand_bits(cand_bits), .cand_len(cand_len)
    );

    pfx_cw_match #(
        .N_CW(N_CW), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W),
        .CW_BITS(CW_BITS), .CW_LENS(CW_LENS)
    ) u_match (
        .cand_bits(cand_bits), .cand_len(cand_len), .hit(hit), .hit_idx(hit_idx)
    );

    pfx_cw_fsm #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst(rst), .tx_strobe(tx_strobe), .rx_ready(rx_ready),
        .hit(hit), .hit_idx(hit_idx), .cand_len(cand_len),
        .shift_en(shift_en), .clear(clear), .tx_go(tx_go),
        .sym_idx(sym_idx), .sym_vld(sym_vld)
    );

endmodule

// File: rtl/pfx_cw_checker.sv
module pfx_cw_checker #(
    parameter int N_CW  = 5,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_strobe,
    input logic             rx_ready,
    input logic             tx_go,
    input logic [IDX_W-1:0] sym_idx,
    input logic             sym_vld
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (tx_go && !sym_vld));

    p_vld_needs_bit_r2: assert property (@(posedge clk) disable iff (rst)
        sym_vld |-> $past(tx_go && tx_strobe));

    p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
        sym_vld |-> (sym_idx < IDX_W'(N_CW)));

    p_vld_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        sym_vld |=> !sym_vld);

    p_go_low_with_vld_r5: assert property (@(posedge clk) disable iff (rst)
        sym_vld |-> !tx_go);

    p_go_held_r5: assert property (@(posedge clk) disable iff (rst)
        (!tx_go && !rx_ready) |=> !tx_go);

    p_go_release_r6: assert property (@(posedge clk) disable iff (rst)
        (!tx_go && rx_ready) |=> tx_go);

    p_idx_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !sym_vld |-> $stable(sym_idx));

endmodule

bind pfx_cw_decoder pfx_cw_checker #(.N_CW(N_CW), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .tx_strobe(tx_strobe), .rx_ready(rx_ready),
    .tx_go(tx_go), .sym_idx(sym_idx), .sym_vld(sym_vld)
);

// File: tb/pfx_cw_decoder_bench.sv
module pfx_cw_decoder_bench;

    localparam int NS = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_data = 1'b0;
    logic       tx_strobe = 1'b0;
    logic       rx_ready = 1'b0;
    logic       tx_go;
    logic [2:0] sym_idx;
    logic       sym_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int last_sym = 0;

    always #10 clk = ~clk;

    pfx_cw_decoder u_pfx_cw_decoder (
        .clk(clk), .rst(rst), .tx_data(tx_data), .tx_strobe(tx_strobe),
        .tx_go(tx_go), .rx_ready(rx_ready), .sym_idx(sym_idx), .sym_vld(sym_vld)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; returns at the next falling edge.
    task automatic put_bit(input logic b);
        tx_strobe = 1'b1;
        tx_data   = b;
        @(negedge clk);
        tx_strobe = 1'b0;
    endtask

    // Symbol s: s ones then a zero, except the last symbol which is all ones.
    task automatic send_sym(input int s, input int gap);
        int len;
        len = (s == NS - 1) ? NS - 1 : s + 1;
        chk(int'(tx_go), 1, "R6 go high before codeword");
        for (int k = 0; k < len; k++) begin
            put_bit((k < s) ? 1'b1 : 1'b0);
            if (k < len - 1) begin
                for (int g = 0; g < gap; g++) @(negedge clk);
                chk(int'(sym_vld), 0, "R2 no early valid mid codeword");
                chk(int'(tx_go), 1, "R2 go stays high mid codeword");
            end
        end
        chk(int'(sym_vld), 1, "R4 valid on last bit");
        chk(int'(sym_idx), s, "R3 decoded index");
        chk(int'(tx_go), 0, "R5 go low with valid");
        last_sym = s;
    endtask

    task automatic release_hold(input int d, input bit junk);
        for (int j = 0; j < d; j++) begin
            if (junk) begin
                tx_strobe = 1'b1;
                tx_data   = j[0];
            end
            @(negedge clk);
            tx_strobe = 1'b0;
            chk(int'(tx_go), 0, "R5 go held low");
            chk(int'(sym_vld), 0, "R4/R7 no valid during hold");
            chk(int'(sym_idx), last_sym, "R8 index held");
        end
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        chk(int'(tx_go), 1, "R6 go high after ready");
        chk(int'(sym_vld), 0, "R4 valid single cycle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(int'(tx_go), 1, "R1 go high in reset");
        chk(int'(sym_vld), 0, "R1 valid low in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(int'(tx_go), 1, "R1 go high after reset");
        chk(int'(sym_vld), 0, "R1 valid low after reset");

        for (int a = 0; a < NS; a++) begin
            for (int b = 0; b < NS; b++) begin
                for (int d = 0; d < 3; d++) begin
                    send_sym(a, (a + d) % 3);
                    release_hold(d, b[0]);
                    send_sym(b, d);
                    release_hold(0, 1'b0);
                end
            end
        end

        // R7: long junk burst during hold, then a one-bit codeword
        send_sym(3, 0);
        release_hold(6, 1'b1);
        send_sym(0, 0);
        chk(int'(sym_idx), 0, "R7 junk bits ignored");
        release_hold(1, 1'b0);

        // R9: reset after two ones of a codeword
        put_bit(1'b1);
        put_bit(1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(int'(tx_go), 1, "R9 go high after mid reset");
        chk(int'(sym_vld), 0, "R9 no valid after mid reset");
        send_sym(0, 0);
        chk(int'(sym_idx), 0, "R9 partial bits discarded");
        release_hold(0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule